// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is a bank of 32-bit control words for chip-level configuration. Software reaches it through a one-cycle select/write/read port. Only whole-word, word-aligned accesses are accepted. A key word guards the bank: writing the key constant opens it, and writing any other value closes it again. Writing while the bank is closed raises a locked-access warning, but the write still lands.

Several locations are read-only. Writes to them are dropped and raise a read-only warning. These locations are the silicon revision, the frequency measurement result, eight scratch words, the random-number output and the two free-running counter words.

The hardware-strap word has two behaviours, and an elaboration parameter picks one. In variant 0 the strap word is plain storage and the revision word is read-only. In variant 1 a write to the strap word ORs the data into it. In the same variant, a write to the revision address clears the strap bits that are set in the data, and the revision word itself does not change. The reset values of the revision and strap words are parameters.

Top module: `sysctl_regbank`

## Requirements
- R1: A write to word index 0 (key) stores 1 when the data equals `KEY_VAL` and 0 for any other data. The bank counts as open while bit 0 of the key word is 1.
- R2: An access whose word index (`addr_i[ADDR_W-1:2]`) is `NUM_REGS` or above changes no storage, returns 0 on `rdata_o`, does not raise `wr_done_o` and raises `err_range_o` during that cycle.
- R3: A write to an index above 0 and below `LOCK_HI` (32) while the bank is closed raises `err_lock_o` and is still committed. An index of 0 or of `LOCK_HI` and above never raises it.
- R4: Writes to indices 3 (frequency result), 8 to 15 (scratch), 16 (random data), 17 and 18 (free-running counter low and high) are dropped, raise `err_ro_o` and keep `wr_done_o` low.
- R5: With `VARIANT` = 1, a write to index 2 (strap) sets the strap word to its old value OR the data.
- R6: With `VARIANT` = 1, a write to index 1 (revision) sets the strap word to its old value AND NOT the data. The revision word is unchanged and `err_ro_o` stays low.
- R7: With `VARIANT` = 0, the strap word takes the full written data. Index 1 is read-only as in R4.
- R8: An access is valid only with `size_i` = 2 (4 bytes) and `addr_i[1:0]` = 0. Any other access raises `err_fmt_o`, writes nothing, returns 0 and raises no other error.
- R9: Every other in-range index is plain read/write storage that takes the full 32-bit word.
- R10: After reset the key word is 0, the revision word is `REV_INIT`, the strap word is `STRAP_INIT` and every other word is 0.
- R11: `rdata_o` shows the addressed word in the same cycle. `wr_done_o` and all error outputs are combinational pulses, high only during a cycle with `sel_i` set. A write is visible on the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access valid this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | log2 of access size in bytes; 2 is the only valid value |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| wr_done_o | output | 1 | Write committed this cycle |
| err_fmt_o | output | 1 | Bad size or misaligned access |
| err_range_o | output | 1 | Index beyond register count |
| err_lock_o | output | 1 | Write inside the guarded range while closed |
| err_ro_o | output | 1 | Write to a read-only word |

## Verification
Some properties are checked on every cycle:
- the key compare result;
- frozen storage after range errors;
- the key state behind every lock warning;
- silence of the errors on bad-format accesses;
- the OR and AND-NOT updates of the strap word in variant 1;
- the absence of any strobe when the port is idle.

The bench scenarios cover the rest:
- the exact read-only index set;
- the lock bound at indices 31 and 32;
- that index truncation does not alias an out-of-range write onto a real word;
- the reset values;
- the way writes to the revision and strap addresses differ between two instances with different variants.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned KEY_IDX     = 0;
  localparam int unsigned REV_IDX     = 1;
  localparam int unsigned STRAP_IDX   = 2;
  localparam int unsigned FREQ_IDX    = 3;
  localparam int unsigned SCR_BASE    = 8;
  localparam int unsigned SCR_NUM     = 8;
  localparam int unsigned RNG_IDX     = 16;
  localparam int unsigned FCNT_IDX    = 17;
  localparam int unsigned FCNT_HI_IDX = 18;

  typedef enum logic [2:0] {
    OP_NONE, OP_PLAIN, OP_KEY, OP_STRAP_OR, OP_STRAP_CLR
  } op_e;

  typedef struct packed {
    logic fmt_err;
    logic range_err;
    logic lock_err;
    logic ro_err;
    op_e  op;
  } acc_t;

  function automatic logic is_ro(input int unsigned idx, input int unsigned variant);
    return (idx == REV_IDX && variant == 0) || idx == FREQ_IDX ||
           (idx >= SCR_BASE && idx < SCR_BASE + SCR_NUM) ||
           idx == RNG_IDX || idx == FCNT_IDX || idx == FCNT_HI_IDX;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned LOCK_HI  = 32,
  parameter int unsigned VARIANT  = 1,
  localparam int unsigned IDX_W   = ADDR_W - 2,
  localparam int unsigned RIDX_W  = $clog2(NUM_REGS)
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              key_open_i,
  output acc_t              acc_o,
  output logic [RIDX_W-1:0] widx_o
);
  logic [IDX_W-1:0] idx;
  int unsigned      idx_n;
  logic             fmt_ok, in_rng, wr_hit, ro;

  always_comb begin
    idx    = addr_i[ADDR_W-1:2];
    idx_n  = {{(32-IDX_W){1'b0}}, idx};
    fmt_ok = (size_i == 2'd2) && (addr_i[1:0] == 2'b00);
    in_rng = idx_n < NUM_REGS;
    wr_hit = sel_i && wr_i && fmt_ok && in_rng;
    ro     = is_ro(idx_n, VARIANT);

    acc_o           = '0;
    acc_o.op        = OP_NONE;
    acc_o.fmt_err   = sel_i && !fmt_ok;
    acc_o.range_err = sel_i && fmt_ok && !in_rng;
    acc_o.lock_err  = wr_hit && !key_open_i && idx_n > KEY_IDX && idx_n < LOCK_HI;
    acc_o.ro_err    = wr_hit && ro;
    if (wr_hit && !ro) begin
      if (idx_n == KEY_IDX)                        acc_o.op = OP_KEY;
      else if (VARIANT == 1 && idx_n == STRAP_IDX) acc_o.op = OP_STRAP_OR;
      else if (VARIANT == 1 && idx_n == REV_IDX)   acc_o.op = OP_STRAP_CLR;
      else                                         acc_o.op = OP_PLAIN;
    end
    widx_o = idx[RIDX_W-1:0];
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned    NUM_REGS   = 64,
  parameter logic [DW-1:0]  KEY_VAL    = 32'hC0DE_5A17,
  parameter logic [DW-1:0]  REV_INIT   = 32'h0402_0303,
  parameter logic [DW-1:0]  STRAP_INIT = 32'h0000_00F0,
  localparam int unsigned   RIDX_W     = $clog2(NUM_REGS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  op_e                          op_i,
  input  logic [RIDX_W-1:0]            widx_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DW-1:0]  regs_o
);
  logic key_match;
  assign key_match = (wdata_i == KEY_VAL);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    localparam logic [DW-1:0] RST = (g == REV_IDX)   ? REV_INIT :
                                    (g == STRAP_IDX) ? STRAP_INIT : '0;
    logic          hit;
    logic [DW-1:0] q, nxt;

    assign hit = (widx_i == RIDX_W'(g));

    always_comb begin
      nxt = q;
      if (hit && op_i == OP_PLAIN) nxt = wdata_i;
      if (g == KEY_IDX && hit && op_i == OP_KEY) nxt = {{(DW-1){1'b0}}, key_match};
      if (g == STRAP_IDX) begin
        if (hit && op_i == OP_STRAP_OR) nxt = q | wdata_i;
        if (op_i == OP_STRAP_CLR)       nxt = q & ~wdata_i;  // issued from revision address
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST;
      else         q <= nxt;
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned   ADDR_W     = 9,
  parameter int unsigned   NUM_REGS   = 64,
  parameter int unsigned   LOCK_HI    = 32,
  parameter int unsigned   VARIANT    = 1,
  parameter logic [31:0]   KEY_VAL    = 32'hC0DE_5A17,
  parameter logic [31:0]   REV_INIT   = 32'h0402_0303,
  parameter logic [31:0]   STRAP_INIT = 32'h0000_00F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              wr_done_o,
  output logic              err_fmt_o,
  output logic              err_range_o,
  output logic              err_lock_o,
  output logic              err_ro_o
);
  localparam int unsigned RIDX_W = $clog2(NUM_REGS);

  acc_t                         acc;
  logic [RIDX_W-1:0]            widx;
  logic [NUM_REGS-1:0][DW-1:0]  regs_q;
  logic                         key_open;

  assign key_open = regs_q[KEY_IDX][0];

  sysctl_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .LOCK_HI(LOCK_HI), .VARIANT(VARIANT)
  ) u_decode (
    .sel_i(sel_i), .wr_i(wr_i), .size_i(size_i), .addr_i(addr_i),
    .key_open_i(key_open), .acc_o(acc), .widx_o(widx)
  );

  sysctl_store #(
    .NUM_REGS(NUM_REGS), .KEY_VAL(KEY_VAL), .REV_INIT(REV_INIT), .STRAP_INIT(STRAP_INIT)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(acc.op), .widx_i(widx),
    .wdata_i(wdata_i), .regs_o(regs_q)
  );

  assign rdata_o     = (sel_i && !acc.fmt_err && !acc.range_err) ? regs_q[widx] : '0;
  assign wr_done_o   = (acc.op != OP_NONE);
  assign err_fmt_o   = acc.fmt_err;
  assign err_range_o = acc.range_err;
  assign err_lock_o  = acc.lock_err;
  assign err_ro_o    = acc.ro_err;
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned VARIANT  = 1,
  parameter logic [31:0] KEY_VAL  = 32'hC0DE_5A17
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         sel_i,
  input logic                         wr_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [31:0]                  wdata_i,
  input logic [31:0]                  rdata_o,
  input logic                         wr_done_o,
  input logic                         err_fmt_o,
  input logic                         err_range_o,
  input logic                         err_lock_o,
  input logic                         err_ro_o,
  input logic                         key_open,
  input logic [NUM_REGS-1:0][DW-1:0]  regs_q
);
  localparam int unsigned IW = ADDR_W - 2;
  logic [IW-1:0] idx;
  logic          ok_wr;
  assign idx   = addr_i[ADDR_W-1:2];
  assign ok_wr = sel_i && wr_i && !err_fmt_o && !err_range_o;

  p_key_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_wr && idx == IW'(KEY_IDX)) |=>
      (regs_q[KEY_IDX] == {31'b0, $past(wdata_i) == KEY_VAL}));

  p_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_range_o |=> $stable(regs_q));

  p_range_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_range_o |-> (rdata_o == '0 && !wr_done_o));

  p_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_lock_o |-> !key_open);

  p_ro_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ro_o |-> !wr_done_o);

  p_fmt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_fmt_o |-> (rdata_o == '0 && !wr_done_o && !err_range_o && !err_ro_o && !err_lock_o));

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> !(wr_done_o || err_fmt_o || err_range_o || err_lock_o || err_ro_o));

  if (VARIANT == 1) begin : g_v1
    p_strap_or_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_done_o && idx == IW'(STRAP_IDX)) |=>
        (regs_q[STRAP_IDX] == $past(regs_q[STRAP_IDX] | wdata_i)));

    p_strap_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_done_o && idx == IW'(REV_IDX)) |=>
        (regs_q[STRAP_IDX] == $past(regs_q[STRAP_IDX] & ~wdata_i) && $stable(regs_q[REV_IDX])));
  end else begin : g_v0
    p_rev_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ok_wr && idx == IW'(REV_IDX)) |-> err_ro_o);
  end
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .VARIANT(VARIANT), .KEY_VAL(KEY_VAL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .wr_done_o(wr_done_o),
  .err_fmt_o(err_fmt_o), .err_range_o(err_range_o), .err_lock_o(err_lock_o),
  .err_ro_o(err_ro_o), .key_open(key_open), .regs_q(regs_q)
);

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/1ps
module sysctl_regbank_bench;
  localparam logic [31:0] KEY   = 32'hC0DE_5A17;
  localparam logic [31:0] REV   = 32'h0402_0303;
  localparam logic [31:0] STRAP = 32'h0000_00F0;

  logic        clk = 0, rst_n = 0;
  logic        sel = 0, wr = 0;
  logic [1:0]  size = 2'd2;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata0;
  logic        done, efmt, erng, elock, ero;
  logic        done0, efmt0, erng0, elock0, ero0;
  int          n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  sysctl_regbank u_sysctl_regbank (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .size_i(size), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .wr_done_o(done), .err_fmt_o(efmt),
    .err_range_o(erng), .err_lock_o(elock), .err_ro_o(ero));

  sysctl_regbank #(.VARIANT(0)) u_sysctl_regbank_v0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .size_i(size), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata0), .wr_done_o(done0), .err_fmt_o(efmt0),
    .err_range_o(erng0), .err_lock_o(elock0), .err_ro_o(ero0));

  // {write byte addr, write data, read byte addr, expected read}
  localparam int NV = 10;
  localparam logic [81:0] VEC [NV] = '{
    {9'h000, KEY,           9'h000, 32'h1},
    {9'h000, 32'h0000_1234, 9'h000, 32'h0},
    {9'h000, KEY,           9'h000, 32'h1},
    {9'h050, 32'hA5A5_0001, 9'h050, 32'hA5A5_0001},
    {9'h008, 32'h0F00_0000, 9'h008, 32'h0F00_00F0},
    {9'h004, 32'h0000_00F0, 9'h008, 32'h0F00_0000},
    {9'h004, 32'h0F00_0000, 9'h004, REV},
    {9'h024, 32'h0000_FFFF, 9'h024, 32'h0},
    {9'h0A0, 32'hDEAD_BEEF, 9'h0A0, 32'hDEAD_BEEF},
    {9'h00C, 32'h0000_0055, 9'h00C, 32'h0}
  };
  localparam string VTAG [NV] = '{"R1", "R1", "R1", "R9", "R5", "R6", "R6", "R4", "R9", "R4"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [8:0] a, input logic [31:0] d,
                       input logic [1:0] sz = 2'd2);
    @(negedge clk);
    sel = 1; wr = w; addr = a; wdata = d; size = sz;
    #5;
  endtask

  task automatic idle();
    @(negedge clk);
    sel = 0; wr = 0; size = 2'd2;
  endtask

  task automatic wr_word(input logic [8:0] a, input logic [31:0] d);
    drive(1'b1, a, d); idle();
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [31:0] exp,
                        input logic v0 = 1'b0);
    drive(1'b0, a, '0);
    chk(tag, v0 ? rdata0 : rdata, exp);
    idle();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset values, both variants
    rd_chk("R10 key", 9'h000, 32'h0);
    rd_chk("R10 rev", 9'h004, REV);
    rd_chk("R10 strap", 9'h008, STRAP);
    rd_chk("R10 plain", 9'h050, 32'h0);
    rd_chk("R10 rev v0", 9'h004, REV, 1'b1);
    rd_chk("R10 strap v0", 9'h008, STRAP, 1'b1);
    // R11 idle strobes
    chk("R11 idle", {27'b0, done, efmt, erng, elock, ero}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr_word(VEC[i][81:73], VEC[i][72:41]);
      rd_chk(VTAG[i], VEC[i][40:32], VEC[i][31:0]);
    end

    // R11 same-cycle strobe, cleared afterwards
    drive(1'b1, 9'h0A0, 32'h1111_2222);
    chk("R11 wr_done", {31'b0, done}, 32'h1);
    idle(); #5;
    chk("R11 wr_done drop", {31'b0, done}, 32'h0);
    rd_chk("R9 plain", 9'h0A0, 32'h1111_2222);

    // R3 lock
    wr_word(9'h000, 32'h0);
    drive(1'b1, 9'h014, 32'h77);
    chk("R3 lock flag", {30'b0, elock, done}, 32'h3);
    idle();
    rd_chk("R3 committed", 9'h014, 32'h77);
    drive(1'b1, 9'h07C, 32'h5); chk("R3 idx31", {31'b0, elock}, 32'h1); idle();
    drive(1'b1, 9'h080, 32'h5); chk("R3 idx32", {31'b0, elock}, 32'h0); idle();
    drive(1'b1, 9'h000, 32'h5); chk("R3 key idx", {31'b0, elock}, 32'h0); idle();

    // R2 range: index 84 truncates onto index 20
    drive(1'b1, 9'h150, 32'h99);
    chk("R2 flag", {30'b0, erng, done}, 32'h2);
    idle();
    rd_chk("R2 no alias", 9'h050, 32'hA5A5_0001);
    drive(1'b0, 9'h100, '0);
    chk("R2 read", rdata, 32'h0);
    chk("R2 read flag", {31'b0, erng}, 32'h1);
    idle();

    // R4 read-only
    drive(1'b1, 9'h040, 32'h1); chk("R4 rng", {30'b0, ero, done}, 32'h2); idle();
    rd_chk("R4 rng val", 9'h040, 32'h0);
    drive(1'b1, 9'h048, 32'h1); chk("R4 fcnt hi", {31'b0, ero}, 32'h1); idle();
    drive(1'b1, 9'h03C, 32'h1); chk("R4 scratch last", {31'b0, ero}, 32'h1); idle();
    drive(1'b1, 9'h01C, 32'h1); chk("R9 idx7 rw", {31'b0, ero}, 32'h0); idle();

    // R6 no read-only flag on revision address, variant 1
    drive(1'b1, 9'h004, 32'h0); chk("R6 no ro", {31'b0, ero}, 32'h0); idle();

    // R7 variant 0
    wr_word(9'h008, 32'h3);
    rd_chk("R7 strap v0", 9'h008, 32'h3, 1'b1);
    drive(1'b1, 9'h004, 32'hFF);
    chk("R7 rev ro v0", {30'b0, ero0, done0}, 32'h2);
    idle();
    rd_chk("R7 rev v0", 9'h004, REV, 1'b1);
    rd_chk("R7 strap kept v0", 9'h008, 32'h3, 1'b1);
    rd_chk("R6 strap cleared", 9'h008, 32'h0);

    // R5 accumulate
    wr_word(9'h008, 32'h1);
    wr_word(9'h008, 32'h2);
    rd_chk("R5 or", 9'h008, 32'h3);
    rd_chk("R7 replace v0", 9'h008, 32'h2, 1'b1);

    // R8 format
    drive(1'b1, 9'h050, 32'h0, 2'd1);
    chk("R8 size", {30'b0, efmt, done}, 32'h2);
    idle();
    drive(1'b1, 9'h052, 32'h0);
    chk("R8 misalign", {29'b0, efmt, erng, done}, 32'h4);
    idle();
    rd_chk("R8 unchanged", 9'h050, 32'hA5A5_0001);
    drive(1'b0, 9'h052, '0);
    chk("R8 read zero", rdata, 32'h0);
    idle();

    wr_word(9'h050, 32'hFFFF_FFFF);
    rd_chk("R9 full word", 9'h050, 32'hFFFF_FFFF);

    summary();
  end
endmodule